// File: doc/BRIEF.md
# Microcoded test-port command sequencer

This block steps through a horizontal microcode store to execute short test-port commands: single clock steps with a chosen mode-select level, a fixed reset sequence, a clock burst, and a serial shift with or without compare. Commands arrive one opcode at a time on a valid/ready stream. Every command starts at the same two shared microwords. The first waits for a command and accepts it. The second translates the latched opcode through a small table into the start address of that command's microcode. Each command's microcode is packed directly after the previous one, so the store holds only as many words as the commands have states.

Each microword carries a next-address field in its top bits, a micro-operation code in the middle, and the control bits in its low bits. The control bits drive the test clock, the mode-select line, the ready handshake and five datapath strobes directly. The datapath sits outside the block. It owns a counter and reports two flags, count-is-zero and count-is-one, which the microcode tests through conditional branches. The machine is pure Moore: all outputs decode from the registered microcode address and change only at rising clock edges.

Top module: `useq_tap_ctrl`

## Requirements
- R1: During and directly after reset, cmd_ready is 1 and tck, tms and every dp_ctrl bit are 0.
- R2: While cmd_valid is 0, cmd_ready stays 1, cmd_data is ignored, and tck, tms and dp_ctrl stay 0.
- R3: An opcode is taken at the rising edge where cmd_ready and cmd_valid are both 1. cmd_ready is 0 from the next cycle until the command ends. cmd_valid and cmd_data have no effect until cmd_ready returns.
- R4: cmd_ready returns exactly 2+W rising edges after the accepting edge, where W is the number of microwords the command executes. Opcodes 0 and 7 execute no words (latency 2) and produce no output activity.
- R5: Opcode 1 gives one tck pulse with tms 0, and opcode 2 gives one tck pulse with tms 1. Each has latency 4.
- R6: Opcode 3 gives RST_PULSES tck pulses, all with tms 1. Its latency is 2+2·RST_PULSES.
- R7: Opcode 4 with count N loaded gives one load strobe (dp_ctrl[0]), then N tck pulses with tms 0, each with a decrement strobe (dp_ctrl[1]). Its latency is 2N+4. N=0 gives no pulse.
- R8: Opcode 5 with count N≥1 gives one load strobe and one serializer load strobe (dp_ctrl[2]). It then gives N tck pulses, each with a shift strobe (dp_ctrl[3]). Only the last pulse has tms 1. It gives N−1 decrements, no compare strobe (dp_ctrl[4]), and has latency 2N+4.
- R9: Opcode 6 behaves as opcode 5 and also gives a compare strobe (dp_ctrl[4]) with every shift strobe.
- R10: tck is never high in two consecutive cycles. While cmd_ready is 1, tck and dp_ctrl are 0. Every decrement strobe coincides with a tck pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | OPW | Command opcode |
| cmd_valid | input | 1 | Opcode valid |
| cmd_ready | output | 1 | Sequencer idle at fetch word, opcode accepted this cycle if valid |
| flags | input | NFLAG | Datapath flags: bit 0 count is zero, bit 1 count is one |
| dp_ctrl | output | 5 | Strobes: 0 load count, 1 decrement, 2 load serializer, 3 shift, 4 compare |
| tms | output | 1 | Test mode-select line |
| tck | output | 1 | Test clock line |

## Verification
The hardest cases to reach are the branch loops. Their exit depends on flags produced outside the block from the block's own strobes. The bench therefore closes the loop with a behavioural counter that loads a bench-chosen count on the load strobe and decrements on the decrement strobe. The counts used include the edge values zero and one. The bench also toggles cmd_valid and cmd_data randomly while a command runs, to show that the latched opcode alone steers execution and that nothing is accepted early.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // micro-operation codes; branches follow from UOP_BR0, two per condition
   localparam int UOP_CONT = 0;
   localparam int UOP_JUMP = 1;
   localparam int UOP_DISP = 2;
   localparam int UOP_BR0  = 3;

   // control field bit positions
   localparam int CB_TCK = 0;
   localparam int CB_TMS = 1;
   localparam int CB_RDY = 2;
   localparam int CB_DP0 = 3;

   // datapath strobe positions within dp_ctrl
   localparam int DP_LDCNT = 0;
   localparam int DP_DEC   = 1;
   localparam int DP_LDSER = 2;
   localparam int DP_SHIFT = 3;
   localparam int DP_CMP   = 4;
   localparam int NDP      = 5;
   localparam int CTLW     = CB_DP0 + NDP;

   // condition indices: 0 is the stream valid, then the datapath flags
   localparam int COND_VALID = 0;
   localparam int COND_ZERO  = 1;
   localparam int COND_ONE   = 2;

   // opcodes
   localparam int OP_STEP0 = 1;
   localparam int OP_STEP1 = 2;
   localparam int OP_TRST  = 3;
   localparam int OP_BURST = 4;
   localparam int OP_SHIFT = 5;
   localparam int OP_SHCMP = 6;

   function automatic int br_code(int cond, bit neg);
      return UOP_BR0 + 2 * cond + (neg ? 1 : 0);
   endfunction

   // packed layout: 2 shared, 2+2 steps, reset, 3 burst, 5+5 shift
   function automatic int s_step0();          return 2;                endfunction
   function automatic int s_step1();          return 4;                endfunction
   function automatic int s_trst();           return 6;                endfunction
   function automatic int s_burst(int rp);    return 6 + 2 * rp;       endfunction
   function automatic int s_shift(int rp);    return s_burst(rp) + 3;  endfunction
   function automatic int s_shcmp(int rp);    return s_shift(rp) + 5;  endfunction
   function automatic int ucode_words(int rp); return s_shcmp(rp) + 5; endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int AW         = 5,
   parameter int UOPW       = 4,
   parameter int OPW        = 3,
   parameter int RST_PULSES = 5,
   localparam int MWW       = AW + UOPW + CTLW
)(
   input  logic [AW-1:0]  upc,
   input  logic [OPW-1:0] op_q,
   output logic [MWW-1:0] uword,
   output logic [AW-1:0]  start_addr
);

   localparam int S_STEP0 = s_step0();
   localparam int S_STEP1 = s_step1();
   localparam int S_TRST  = s_trst();
   localparam int S_BURST = s_burst(RST_PULSES);
   localparam int S_SHIFT = s_shift(RST_PULSES);
   localparam int S_SHCMP = s_shcmp(RST_PULSES);
   localparam int NOPS    = 2 ** OPW;
   localparam int NWORDS  = 2 ** AW;

   localparam int TCKB = 1 << CB_TCK;
   localparam int TMSB = 1 << CB_TMS;
   localparam int RDYB = 1 << CB_RDY;
   localparam int LDB  = 1 << (CB_DP0 + DP_LDCNT);
   localparam int DECB = 1 << (CB_DP0 + DP_DEC);
   localparam int LSB_ = 1 << (CB_DP0 + DP_LDSER);
   localparam int SHB  = 1 << (CB_DP0 + DP_SHIFT);
   localparam int CMPB = 1 << (CB_DP0 + DP_CMP);

   function automatic logic [MWW-1:0] mk(int nxt, int uop, int ctl);
      logic [MWW-1:0] w;
      w = '0;
      w[MWW-1 -: AW]  = AW'(nxt);
      w[CTLW +: UOPW] = UOPW'(uop);
      w[0 +: CTLW]    = CTLW'(ctl);
      return w;
   endfunction

   function automatic logic [MWW-1:0] word_at(int a);
      int k, base, c;
      if (a == 0)            return mk(0, br_code(COND_VALID, 1'b1), RDYB);
      if (a == 1)            return mk(0, UOP_DISP, 0);
      if (a == S_STEP0)      return mk(0, UOP_CONT, 0);
      if (a == S_STEP0 + 1)  return mk(0, UOP_JUMP, TCKB);
      if (a == S_STEP1)      return mk(0, UOP_CONT, TMSB);
      if (a == S_STEP1 + 1)  return mk(0, UOP_JUMP, TMSB | TCKB);
      if (a >= S_TRST && a < S_BURST) begin
         k = a - S_TRST;
         if (k % 2 == 0)               return mk(0, UOP_CONT, TMSB);
         if (k == 2 * RST_PULSES - 1)  return mk(0, UOP_JUMP, TMSB | TCKB);
         return mk(0, UOP_CONT, TMSB | TCKB);
      end
      if (a == S_BURST)      return mk(0, UOP_CONT, LDB);
      if (a == S_BURST + 1)  return mk(0, br_code(COND_ZERO, 1'b0), 0);
      if (a == S_BURST + 2)  return mk(S_BURST + 1, UOP_JUMP, TCKB | DECB);
      if (a >= S_SHIFT && a < S_SHCMP + 5) begin
         base = (a < S_SHCMP) ? S_SHIFT : S_SHCMP;
         c    = (a < S_SHCMP) ? 0 : CMPB;
         k    = a - base;
         case (k)
            0:       return mk(0, UOP_CONT, LDB | LSB_);
            1:       return mk(base + 3, br_code(COND_ONE, 1'b0), 0);
            2:       return mk(base + 1, UOP_JUMP, TCKB | SHB | DECB | c);
            3:       return mk(0, UOP_CONT, TMSB);
            default: return mk(0, UOP_JUMP, TMSB | TCKB | SHB | c);
         endcase
      end
      return mk(0, UOP_JUMP, 0);
   endfunction

   function automatic int start_of(int op);
      case (op)
         OP_STEP0: return S_STEP0;
         OP_STEP1: return S_STEP1;
         OP_TRST:  return S_TRST;
         OP_BURST: return S_BURST;
         OP_SHIFT: return S_SHIFT;
         OP_SHCMP: return S_SHCMP;
         default:  return 0;
      endcase
   endfunction

   logic [MWW-1:0] rom [NWORDS];
   logic [AW-1:0]  tbl [NOPS];

   for (genvar a = 0; a < NWORDS; a++) begin : g_word
      assign rom[a] = word_at(a);
   end

   for (genvar o = 0; o < NOPS; o++) begin : g_tbl
      assign tbl[o] = AW'(start_of(o));
   end

   assign uword      = rom[upc];
   assign start_addr = tbl[op_q];

endmodule

// File: rtl/useq_condmux.sv
module useq_condmux
   import useq_pkg::*;
#(
   parameter int NCOND = 3,
   parameter int UOPW  = 4
)(
   input  logic [NCOND-1:0] cond,
   input  logic [UOPW-1:0]  uop,
   output logic             take
);

   localparam int NBR = 2 * NCOND;

   logic [NBR-1:0] hit;

   for (genvar k = 0; k < NCOND; k++) begin : g_cond
      assign hit[2*k]   = (uop == UOPW'(UOP_BR0 + 2*k))     &&  cond[k];
      assign hit[2*k+1] = (uop == UOPW'(UOP_BR0 + 2*k + 1)) && !cond[k];
   end

   assign take = |hit;

endmodule

// File: rtl/useq_seq.sv
module useq_seq
   import useq_pkg::*;
#(
   parameter int AW   = 5,
   parameter int UOPW = 4,
   parameter int OPW  = 3
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [UOPW-1:0] uop,
   input  logic [AW-1:0]  nxt,
   input  logic [AW-1:0]  start_addr,
   input  logic           take,
   input  logic           accept,
   input  logic [OPW-1:0] cmd_data,
   output logic [AW-1:0]  upc,
   output logic [OPW-1:0] op_q
);

   logic [AW-1:0] upc_d;

   always_comb begin
      if (uop == UOPW'(UOP_JUMP))
         upc_d = nxt;
      else if (uop == UOPW'(UOP_DISP))
         upc_d = start_addr;
      else if (take)
         upc_d = nxt;
      else
         upc_d = upc + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc  <= '0;
         op_q <= '0;
      end else begin
         upc <= upc_d;
         if (accept)
            op_q <= cmd_data;
      end
   end

endmodule

// File: rtl/useq_tap_ctrl.sv
module useq_tap_ctrl
   import useq_pkg::*;
#(
   parameter int OPW        = 3,
   parameter int NFLAG      = 2,
   parameter int RST_PULSES = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPW-1:0]   cmd_data,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [NFLAG-1:0] flags,
   output logic [NDP-1:0]   dp_ctrl,
   output logic             tms,
   output logic             tck
);

   localparam int NCOND = NFLAG + 1;
   localparam int DEPTH = ucode_words(RST_PULSES);
   localparam int AW    = $clog2(DEPTH);
   localparam int UOPW  = $clog2(UOP_BR0 + 2 * NCOND);
   localparam int MWW   = AW + UOPW + CTLW;

   if (OPW < 3) begin : g_bad_opw
      $error("OPW must be at least 3 to encode all commands");
   end
   if (NFLAG < 2) begin : g_bad_flag
      $error("NFLAG must be at least 2 (zero and one flags)");
   end
   if (RST_PULSES < 1) begin : g_bad_rst
      $error("RST_PULSES must be at least 1");
   end

   logic [AW-1:0]   upc;
   logic [OPW-1:0]  op_q;
   logic [MWW-1:0]  uword;
   logic [AW-1:0]   start_addr;
   logic [AW-1:0]   nxt;
   logic [UOPW-1:0] uop;
   logic [CTLW-1:0] ctl;
   logic [NCOND-1:0] cond;
   logic            take;
   logic            accept;

   useq_rom #(
      .AW(AW), .UOPW(UOPW), .OPW(OPW), .RST_PULSES(RST_PULSES)
   ) u_rom (
      .upc(upc), .op_q(op_q), .uword(uword), .start_addr(start_addr)
   );

   assign nxt  = uword[MWW-1 -: AW];
   assign uop  = uword[CTLW +: UOPW];
   assign ctl  = uword[CTLW-1:0];
   assign cond = {flags, cmd_valid};

   useq_condmux #(
      .NCOND(NCOND), .UOPW(UOPW)
   ) u_cond (
      .cond(cond), .uop(uop), .take(take)
   );

   assign accept = ctl[CB_RDY] & cmd_valid;

   useq_seq #(
      .AW(AW), .UOPW(UOPW), .OPW(OPW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .uop(uop), .nxt(nxt),
      .start_addr(start_addr), .take(take), .accept(accept),
      .cmd_data(cmd_data), .upc(upc), .op_q(op_q)
   );

   assign cmd_ready = ctl[CB_RDY];
   assign tck       = ctl[CB_TCK];
   assign tms       = ctl[CB_TMS];
   assign dp_ctrl   = ctl[CB_DP0 +: NDP];

endmodule

// File: rtl/useq_tap_ctrl_chk.sv
module useq_tap_ctrl_chk
   import useq_pkg::*;
#(
   parameter int OPW        = 3,
   parameter int NFLAG      = 2,
   parameter int RST_PULSES = 5
)(
   input logic             clk,
   input logic             rst_n,
   input logic [OPW-1:0]   cmd_data,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [NFLAG-1:0] flags,
   input logic [NDP-1:0]   dp_ctrl,
   input logic             tms,
   input logic             tck
);

   logic accept;
   assign accept = cmd_ready && cmd_valid;

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready && !cmd_valid |=> cmd_ready);

   a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_ready);

   a_r4_nop_return: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (cmd_data == OPW'(0) || cmd_data == OPW'(7)) |=> ##1 cmd_ready);

   a_r5_step_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      accept && cmd_data == OPW'(OP_STEP0) |=> ##2 (tck && !tms));

   a_r7_dec_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dp_ctrl[DP_DEC] |-> tck);

   a_r10_tck_single: assert property (@(posedge clk) disable iff (!rst_n)
      tck |=> !tck);

   a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!tck && dp_ctrl == '0));

endmodule

bind useq_tap_ctrl useq_tap_ctrl_chk #(
   .OPW(OPW), .NFLAG(NFLAG), .RST_PULSES(RST_PULSES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready), .flags(flags), .dp_ctrl(dp_ctrl),
   .tms(tms), .tck(tck)
);

// File: tb/tb_useq_tap_ctrl.sv
`timescale 1ns/1ps
module tb_useq_tap_ctrl;
   import useq_pkg::*;

   localparam int OPW = 3;
   localparam int NFLAG = 2;
   localparam int RP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [OPW-1:0] cmd_data = '0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [NFLAG-1:0] flags;
   logic [NDP-1:0] dp_ctrl;
   logic tms, tck;

   int tests = 0;
   int fails = 0;
   int load_n = 0;
   int cnt = 0;
   bit done = 1'b0;

   typedef struct {
      int lat, pulses, tms1, ld, dec, ldser, shifts, cmps;
   } ex_t;

   always #2.5 clk = ~clk;

   // behavioural datapath counter closing the flag loop
   always @(posedge clk) begin
      if (dp_ctrl[DP_LDCNT])    cnt <= load_n;
      else if (dp_ctrl[DP_DEC]) cnt <= cnt - 1;
   end
   assign flags = {cnt == 1, cnt == 0};

   useq_tap_ctrl #(.OPW(OPW), .NFLAG(NFLAG), .RST_PULSES(RP)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .flags(flags), .dp_ctrl(dp_ctrl),
      .tms(tms), .tck(tck)
   );

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic ex_t expect_of(int op, int n);
      ex_t e;
      e = '{2, 0, 0, 0, 0, 0, 0, 0};
      case (op)
         1: e = '{4, 1, 0, 0, 0, 0, 0, 0};
         2: e = '{4, 1, 1, 0, 0, 0, 0, 0};
         3: e = '{2 + 2*RP, RP, RP, 0, 0, 0, 0, 0};
         4: e = '{2*n + 4, n, 0, 1, n, 0, 0, 0};
         5: e = '{2*n + 4, n, 1, 1, n - 1, 1, n, 0};
         6: e = '{2*n + 4, n, 1, 1, n - 1, 1, n, n};
         default: ;
      endcase
      return e;
   endfunction

   function automatic string tag_of(int op);
      case (op)
         1, 2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         default: return "R4";
      endcase
   endfunction

   task automatic check_quiet(string tag);
      check({tag, " ready"}, int'(cmd_ready), 1);
      check({tag, " tck"}, int'(tck), 0);
      check({tag, " tms"}, int'(tms), 0);
      check({tag, " dp_ctrl"}, int'(dp_ctrl), 0);
   endtask

   task automatic run_cmd(int op, int n, bit noisy);
      ex_t e;
      string t;
      int lat = 0, pulses = 0, tms1 = 0, ld = 0, dec = 0;
      int ldser = 0, shifts = 0, cmps = 0, dbl = 0;
      bit last_tms = 1'b0, prev_tck = 1'b0;
      e = expect_of(op, n);
      t = tag_of(op);
      load_n = n;
      @(negedge clk);
      check("R3 ready before issue", int'(cmd_ready), 1);
      cmd_valid = 1'b1;
      cmd_data  = OPW'(op);
      while (1) begin
         @(negedge clk);
         lat++;
         if (cmd_ready || lat > 400) break;
         if (tck) begin
            pulses++;
            if (tms) tms1++;
            last_tms = tms;
            if (prev_tck) dbl++;
         end
         prev_tck = tck;
         if (dp_ctrl[DP_LDCNT]) ld++;
         if (dp_ctrl[DP_DEC])   dec++;
         if (dp_ctrl[DP_LDSER]) ldser++;
         if (dp_ctrl[DP_SHIFT]) shifts++;
         if (dp_ctrl[DP_CMP])   cmps++;
         cmd_valid = noisy ? 1'($urandom % 2) : 1'b0;
         cmd_data  = OPW'($urandom);
      end
      cmd_valid = 1'b0;
      check({t, noisy ? " R3 latency under noise" : " latency"}, lat, e.lat);
      check({t, " pulses"}, pulses, e.pulses);
      check({t, " tms-high pulses"}, tms1, e.tms1);
      check({t, " count loads"}, ld, e.ld);
      check({t, " decrements"}, dec, e.dec);
      check({t, " serializer loads"}, ldser, e.ldser);
      check({t, " shifts"}, shifts, e.shifts);
      check({t, " compares"}, cmps, e.cmps);
      check("R10 no double tck", dbl, 0);
      if (op == 5 || op == 6)
         check({t, " last pulse tms"}, int'(last_tms), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1149));
      // R1: reset state
      repeat (3) @(negedge clk);
      check_quiet("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R1 after reset");

      // R2: idle with junk data
      for (int i = 0; i < 8; i++) begin
         cmd_data = OPW'($urandom);
         @(negedge clk);
         check_quiet("R2 idle");
      end

      // directed corners
      run_cmd(0, 0, 1'b0);
      run_cmd(7, 0, 1'b0);
      run_cmd(1, 0, 1'b0);
      run_cmd(2, 0, 1'b0);
      run_cmd(3, 0, 1'b0);
      run_cmd(4, 0, 1'b0);
      run_cmd(4, 1, 1'b0);
      run_cmd(4, 9, 1'b0);
      run_cmd(5, 1, 1'b0);
      run_cmd(5, 2, 1'b0);
      run_cmd(6, 1, 1'b0);
      run_cmd(6, 7, 1'b1);
      run_cmd(3, 0, 1'b1);

      // R1: reset in the middle of a burst
      load_n = 10;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = OPW'(4);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_quiet("R1 reset mid-command");
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R1 release mid-command");

      // constrained random
      for (int i = 0; i < 150; i++) begin
         int op, n;
         op = int'($urandom % 8);
         n  = int'($urandom % 13);
         if ((op == 5 || op == 6) && n == 0) n = 1;
         repeat (int'($urandom % 3)) begin
            cmd_data = OPW'($urandom);
            @(negedge clk);
            check("R2 ready idle", int'(cmd_ready), 1);
         end
         run_cmd(op, n, 1'($urandom % 2));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule